// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus (I2C-style) in front of a 512-byte memory held in on-chip registers. It watches the clock and data lines with the system clock, finds start and stop conditions, and reads the first byte after every start as an address byte. That byte holds a fixed device code, two device-select bits, a block-select bit and a direction bit. When the code and the select bits match, the block acknowledges. A write then takes a word address followed by any number of data bytes. A read streams bytes for as long as the master acknowledges them.

An internal 9-bit address counter is kept between transfers. Writes take effect at bus speed, with no busy period. The block therefore never stretches the clock and never withholds an acknowledge to signal that it is busy. A random read is a write of the word address alone, then a repeated start and a read. A single protect input blocks every change to the array.

The block drives the data line low only, through an open-drain enable. The clock is an input only.

Top module: `i2c_fram_slave`

## Requirements
- R1: After reset, `sda_oe` is 0. A byte clocked in without a preceding start is never acknowledged.
- R2: The address byte is, MSB first, the code 1010, two device-select bits equal to `dev_sel[1:0]`, a block bit, then R/W (1 = read). On a match the block pulls SDA low in the ninth clock. Otherwise it stays silent and ignores the bus until the next start.
- R3: In a write, the byte after the address byte loads the counter with {block bit, byte}. Each data byte is stored at the counter, acknowledged, and the counter then increments.
- R4: The counter is 9 bits wide and wraps from 0x1FF to 0x000, in both writes and reads.
- R5: A random read returns the byte at {block bit, word address}. It is formed from a write of the word address only, then a repeated start and a read.
- R6: During a read, each byte goes out MSB first and SDA is released in the acknowledge slot. A master acknowledge gets the next sequential byte. A missing acknowledge ends the read with SDA released.
- R7: A read begins at {block bit of the read address byte, counter bits 7:0}. The counter keeps its value across transfers, so a current-address read continues one past the last byte accessed.
- R8: While `wp` is 1, data bytes are still acknowledged and the counter still advances, but the array keeps its contents.
- R9: A stop or a start at any point releases SDA and abandons the byte in progress. A partly received byte changes neither the array nor the counter.
- R10: Apart from the release on a start or stop, `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad (wired-AND level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| dev_sel | input | 2 | Strap value matched against the device-select bits |
| wp | input | 1 | 1 protects the whole array; tie to 0 when unused |

## Verification
The assertions assume that SCL and SDA reach the block already synchronous to `clk`. They also assume that the master changes SDA only while SCL is low, except when it forms a start or stop. A start or stop that crossed a clock edge would otherwise look like a data bit.

The bench drives both lines on the falling edge of `clk`. It holds every SCL phase for six clock cycles, changes SDA only inside the low phase, and frames start and stop with SCL held high across the SDA edge. It also samples the wired-AND level twice during every high phase of a read, to confirm that the slave holds its data steady.

// File: rtl/i2c_fram_slave.sv
module i2c_fram_slave #(
  parameter int          ADDR_W = 9,
  parameter logic [3:0]  DEV_ID = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [1:0] dev_sel,
  input  logic       wp
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ONE = 1;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WORD, S_WR, S_RD} st_t;

  logic              scl_q, scl_d, sda_q, sda_d;
  st_t               st;
  logic [3:0]        cnt;
  logic [7:0]        rx;
  logic [6:0]        tx;
  logic [ADDR_W-1:0] addr;
  logic              blk, rw, mack;
  logic [7:0]        mem [DEPTH];

  wire start_c = scl_q & scl_d & sda_d & ~sda_q;
  wire stop_c  = scl_q & scl_d & ~sda_d & sda_q;
  wire rise    = scl_q & ~scl_d;
  wire fall    = ~scl_q & scl_d;
  wire dev_hit = (rx[7:4] == DEV_ID) && (rx[3:2] == dev_sel);

  wire [ADDR_W-1:0] ld_addr = (st == S_DEV) ? {blk, addr[7:0]} : addr;
  wire [7:0]        ld_byte = mem[ld_addr];
  wire              wr_en   = fall && (st == S_WR) && (cnt == 4'd8) && !wp
                              && !start_c && !stop_c;

  always_ff @(posedge clk)
    if (wr_en) mem[addr] <= rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1; scl_d <= 1'b1; sda_q <= 1'b1; sda_d <= 1'b1;
      st <= S_IDLE; cnt <= '0; rx <= '0; tx <= '0;
      addr <= '0; blk <= 1'b0; rw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
    end else begin
      scl_q <= scl_in; scl_d <= scl_q;
      sda_q <= sda_in; sda_d <= sda_q;
      if (start_c) begin
        st <= S_DEV; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; cnt <= '0; sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (rise) begin
          if (cnt < 4'd8) begin
            rx  <= {rx[6:0], sda_q};
            cnt <= cnt + 4'd1;
          end else if (cnt == 4'd8) begin
            mack <= ~sda_q;
            cnt  <= 4'd9;
          end
        end else if (fall) begin
          if (cnt == 4'd8) begin
            case (st)
              S_DEV:
                if (dev_hit) begin
                  sda_oe <= 1'b1; blk <= rx[1]; rw <= rx[0];
                end else begin
                  st <= S_IDLE; cnt <= '0;
                end
              S_WORD: begin addr <= {blk, rx}; sda_oe <= 1'b1; end
              S_WR:   begin addr <= addr + ONE; sda_oe <= 1'b1; end
              default: sda_oe <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt    <= '0;
            sda_oe <= 1'b0;
            case (st)
              S_DEV:
                if (rw) begin
                  st <= S_RD; tx <= ld_byte[6:0];
                  sda_oe <= ~ld_byte[7]; addr <= ld_addr + ONE;
                end else st <= S_WORD;
              S_WORD: st <= S_WR;
              S_RD:
                if (mack) begin
                  tx <= ld_byte[6:0];
                  sda_oe <= ~ld_byte[7]; addr <= ld_addr + ONE;
                end else st <= S_IDLE;
              default: ;
            endcase
          end else if (st == S_RD && cnt != 4'd0) begin
            sda_oe <= ~tx[6];
            tx     <= {tx[5:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

module i2c_fram_slave_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_q,
  input logic              start_c,
  input logic              stop_c,
  input logic              sda_oe,
  input logic [2:0]        st,
  input logic [3:0]        cnt,
  input logic              wp,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        mem [1 << ADDR_W]
);
  logic              prev_wp;
  logic [ADDR_W-1:0] prev_addr;
  logic [7:0]        prev_val;

  a_r9_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> !sda_oe);

  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe) && !$past(start_c || stop_c)) |-> !$past(scl_q));

  a_r6_master_ack_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && cnt == 4'd9) |-> !sda_oe);

  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe);

  always_ff @(posedge clk) begin
    prev_wp   <= rst_n && wp;
    prev_addr <= addr;
    prev_val  <= mem[addr];
    if (rst_n && prev_wp)
      a_r8_wp_holds_array: assert (mem[prev_addr] == prev_val)
        else $error("protected byte changed at %0h", prev_addr);
  end
endmodule

bind i2c_fram_slave i2c_fram_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .start_c(start_c), .stop_c(stop_c),
  .sda_oe(sda_oe), .st(st), .cnt(cnt), .wp(wp), .addr(addr), .mem(mem)
);

// File: tb/tb_i2c_fram_slave.sv
`timescale 1ns/1ps
module tb_i2c_fram_slave;
  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [1:0] dev_sel = 2'b10;
  logic sda_oe, sda_line;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  localparam int H = 6;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_fram_slave dut (.clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
                      .sda_oe(sda_oe), .dev_sel(dev_sel), .wp(wp));

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H); m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(H);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(H); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0;
    end
    m_sda = 1'b1; tick(H); m_scl = 1'b1; tick(H/2); ack = !sda_line; tick(H/2); m_scl = 1'b0;
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] b);
    bit steady = 1;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      logic v1;
      tick(H); m_scl = 1'b1; tick(1); v1 = sda_line;
      tick(H/2 - 1); b[i] = sda_line; tick(H/2);
      if (sda_line != v1) steady = 0;
      m_scl = 1'b0;
    end
    check(steady, "R10 data steady while SCL high", steady, 1);
    m_sda = give_ack ? 1'b0 : 1'b1; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0; m_sda = 1'b1;
  endtask

  function automatic logic [7:0] abyte(bit blk, bit rd);
    return {4'b1010, dev_sel, blk, rd};
  endfunction

  task automatic write_bytes(bit blk, logic [7:0] word, logic [7:0] d [4], int n, string req);
    bit ack;
    bus_start;
    send(abyte(blk, 0), ack); check(ack, {req, " address ack"}, ack, 1);
    send(word, ack);          check(ack, {req, " word ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send(d[i], ack); check(ack, {req, " data ack"}, ack, 1);
    end
    bus_stop;
  endtask

  task automatic read_body(bit blk, logic [7:0] exp [4], int n, string req);
    bit ack;
    logic [7:0] b;
    send(abyte(blk, 1), ack); check(ack, {req, " read address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv(i != n - 1, b); check(b == exp[i], {req, " read data"}, b, exp[i]);
    end
    tick(2);
    check(!sda_oe, "R6 released after no-ack", sda_oe, 0);
    bus_stop;
  endtask

  task automatic read_random(bit blk, logic [7:0] word, logic [7:0] exp [4], int n, string req);
    bit ack;
    bus_start;
    send(abyte(blk, 0), ack); check(ack, {req, " dummy address ack"}, ack, 1);
    send(word, ack);          check(ack, {req, " dummy word ack"}, ack, 1);
    bus_start;
    read_body(blk, exp, n, req);
  endtask

  task automatic read_current(bit blk, logic [7:0] exp [4], int n, string req);
    bus_start;
    read_body(blk, exp, n, req);
  endtask

  task automatic t_reset;
    bit ack;
    check(!sda_oe, "R1 sda_oe in reset", sda_oe, 0);
    tick(4); rst_n = 1'b1; tick(4);
    check(!sda_oe, "R1 sda_oe after reset", sda_oe, 0);
    m_scl = 1'b0; tick(H);
    send(abyte(0, 0), ack); check(!ack, "R1 no ack without start", ack, 0);
    m_sda = 1'b0; tick(H); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
  endtask

  task automatic t_mismatch;
    bit ack;
    logic [7:0] b;
    bus_start;
    send({4'b1010, 2'b01, 1'b0, 1'b0}, ack); check(!ack, "R2 wrong select bits", ack, 0);
    send(abyte(0, 0), ack);                  check(!ack, "R2 ignored until start", ack, 0);
    bus_stop;
    bus_start;
    send({4'b1110, dev_sel, 1'b0, 1'b1}, ack); check(!ack, "R2 wrong device code", ack, 0);
    recv(0, b); check(b == 8'hFF, "R2 silent after miss", b, 8'hFF);
    bus_stop;
  endtask

  task automatic t_byte_write;
    write_bytes(0, 8'h05, '{8'hC3, 0, 0, 0}, 1, "R3");
    read_random(0, 8'h05, '{8'hC3, 0, 0, 0}, 1, "R5");
  endtask

  task automatic t_sequential;
    write_bytes(0, 8'h10, '{8'h11, 8'h22, 8'h33, 8'h44}, 4, "R3 sequential");
    read_random(0, 8'h10, '{8'h11, 8'h22, 8'h33, 8'h44}, 4, "R6 sequential");
  endtask

  task automatic t_wrap;
    write_bytes(1, 8'hFE, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, 4, "R4 write wrap");
    read_random(1, 8'hFE, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, 4, "R4 read wrap");
  endtask

  task automatic t_current;
    read_random(1, 8'hFE, '{8'hA1, 8'hA2, 0, 0}, 2, "R7 setup");
    read_current(0, '{8'hA3, 0, 0, 0}, 1, "R7 after wrap");
    read_current(0, '{8'hA4, 0, 0, 0}, 1, "R7 counter kept");
  endtask

  task automatic t_protect;
    wp = 1'b1;
    write_bytes(0, 8'h10, '{8'h5A, 0, 0, 0}, 1, "R8 protected");
    wp = 1'b0;
    read_current(0, '{8'h22, 0, 0, 0}, 1, "R8 counter advanced");
    read_random(0, 8'h10, '{8'h11, 0, 0, 0}, 1, "R8 array kept");
  endtask

  task automatic t_abort;
    bit ack;
    bus_start;
    send(abyte(0, 0), ack); check(ack, "R9 address ack", ack, 1);
    send(8'h12, ack);       check(ack, "R9 word ack", ack, 1);
    for (int i = 0; i < 3; i++) begin
      m_sda = 1'b0; tick(H); m_scl = 1'b1; tick(H); m_scl = 1'b0;
    end
    bus_stop;
    check(!sda_oe, "R9 released on stop", sda_oe, 0);
    read_current(0, '{8'h33, 0, 0, 0}, 1, "R9 partial byte dropped");
  endtask

  initial begin
    t_reset;
    t_mismatch;
    t_byte_write;
    t_sequential;
    t_wrap;
    t_current;
    t_protect;
    t_abort;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule